// File: doc/BRIEF.md
# External Bus Chip-Select Timing Controller

This block runs the bus cycles for one chip-select region of a multiplexed external address/data bus. A small control register holds the region's settings: the data bus width, the wait-state code for the strobe phase, the number of idle recovery cycles after a read, the chip-select waveform kind, and two pin-enable bits. The chip-select pin is shared with a general-purpose port, so it is driven only when both pin-enable bits are set.

When the requester asks for an access, the block samples the configuration and starts the access. The address phase lasts one cycle: the address latch enable is high and the address is driven on the shared lines. The strobe phase follows, with read or write strobe low. Its length comes from a fixed wait count, or from one fixed wait cycle plus an extension for as long as the external wait input is held. On an 8-bit bus a 16-bit request becomes two byte accesses, low byte first. Reads end with 0, 1 or 2 idle recovery cycles, and no new request is taken until they are over. Illegal settings raise an error pulse, and no bus cycle is started.

Top module: `extbus_cs_ctrl`

## Requirements
- R1: After reset all strobes and the chip select are inactive, `busy`, `ready`, `err` and `cs_drive` are 0, and the control register is zero. A request made with the reset configuration runs as a 16-bit read with a one-cycle strobe, followed by 2 recovery cycles.
- R2: Each byte or word access has exactly one address cycle, with `ale`=1, `ad_oe`=1 and the address on `ad_out`. Strobe cycles follow immediately, with `rd_n` low for a read or `wr_n` low for a write and never both. While the pin is driven, `cs_n` is low from the address cycle through the last strobe cycle and high at all other times.
- R3: Wait codes 0..7 (control bits [3:0]) give a strobe phase of exactly 1 + code cycles per byte or word access.
- R4: Wait code 15 gives one strobe cycle plus one fixed wait cycle. The wait input is sampled in the fixed wait cycle and in each later one; each cycle in which it is high adds one more wait cycle.
- R5: If a request finds a wait code of 8..14, a recovery code of 3 (bits [5:4]), or a waveform code (bits [8:7]) other than 0, then `err` goes high for one cycle, in the cycle after the request. No address cycle occurs and `busy` stays 0.
- R6: After the final strobe of a read, `busy` stays high for recovery cycles that depend on recovery code 0, 1 or 2: 2, 1 or 0 cycles respectively. Writes get no recovery cycles.
- R7: A request held high during recovery is not accepted before recovery ends. The next address cycle comes 2 cycles after the last recovery cycle.
- R8: With bit [6]=0 (16-bit bus), a read returns `ad_in` on `rdata`, and a write drives `req_wdata` on `ad_out` with `ad_oe`=1 during the strobe.
- R9: With bit [6]=1 (8-bit bus), a request with `req_word`=1 runs two complete byte accesses, the first at the address and the second at address+1. The low byte is carried on `ad[7:0]` first, and `rdata` returns {second byte, first byte}. With `req_word`=0 there is one byte access, and `rdata` returns the byte zero-extended. In 8-bit mode `ad_in[15:8]` is ignored.
- R10: `ready` is a one-cycle pulse in the last strobe cycle of the final byte or word access, with `rdata` valid in that same cycle.
- R11: `cs_drive` is 1 only when bits [9] and [10] are both 1. While `cs_drive` is 0, `cs_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 11 | Control word: [3:0] wait code, [5:4] recovery code, [6] 8-bit bus, [8:7] waveform code, [9] port-control enable, [10] port-function enable |
| req | input | 1 | Access request, taken when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 16-bit request (splits on an 8-bit bus) |
| req_addr | input | AD_W | Access address |
| req_wdata | input | AD_W | Write data |
| ready | output | 1 | Pulse on the last strobe cycle of an access |
| err | output | 1 | Pulse when a request meets an illegal configuration |
| busy | output | 1 | Access or recovery in progress |
| rdata | output | AD_W | Read data, valid with `ready` |
| ale | output | 1 | Address latch enable |
| cs_n | output | 1 | Chip select, active low |
| cs_drive | output | 1 | Chip-select pin output enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_out | output | AD_W | Multiplexed address/data out |
| ad_oe | output | 1 | Output enable for `ad_out` |
| ad_in | input | AD_W | Multiplexed data in |
| wait_in | input | 1 | External wait request, high = extend |

## Verification
The hardest case to reach is the externally extended strobe: the wait input only counts in the fixed wait cycle and the cycles after it, and it feeds `ready` within the same cycle. The bench therefore tracks the strobe index of each byte at the falling edge. It raises the wait input for a chosen number of cycles, starting at the second strobe cycle, and only then samples `ready`. The same timing is run for two-byte accesses on the 8-bit bus, so the count restarts for each byte. Recovery blocking is reached by holding the request high through a whole read and measuring the gap to the next address cycle.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

    localparam int WCODE_W = 4;
    localparam int RCODE_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_STRB = 2'd2,
        ST_RCV  = 2'd3
    } seq_st_e;

    typedef struct packed {
        logic               pin_fn;
        logic               pin_ctl;
        logic [1:0]         mode;
        logic               narrow;
        logic [RCODE_W-1:0] rcode;
        logic [WCODE_W-1:0] wcode;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    function automatic logic cfg_legal(input cfg_t c);
        logic wait_ok;
        wait_ok = !c.wcode[WCODE_W-1] || (&c.wcode);
        return wait_ok && (c.rcode != 2'b11) && (c.mode == 2'b00);
    endfunction

    function automatic logic [RCODE_W-1:0] rcv_cycles(input logic [RCODE_W-1:0] code);
        case (code)
            2'b00:   return 2'd2;
            2'b01:   return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/extbus_cfg_reg.sv
module extbus_cfg_reg
    import extbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg,
    output logic             legal
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) cfg_d = cfg_t'(wdata);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg   = cfg_q;
    assign legal = cfg_legal(cfg_q);

    // R1: a register that has just come out of reset holds zero
    assert_cfg_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (cfg == '0));

endmodule

// File: rtl/extbus_wait_ctr.sv
module extbus_wait_ctr #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] lim,
    input  logic             ext,
    input  logic             wait_in,
    output logic             last
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] lim_eff;
    logic             at_lim;

    always_comb begin
        lim_eff = ext ? CNT_W'(1) : lim;
        at_lim  = (cnt_q == lim_eff);
        last    = run && at_lim && !(ext && wait_in);
        cnt_d   = cnt_q;
        if (!run || last) cnt_d = '0;
        else if (!at_lim) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: a fixed-count strobe never runs past its programmed length
    assert_fixed_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ext && cnt_q == lim) |=> (!run || cnt_q == '0));

    // R4: a wait request in the sampled cycle keeps the strobe going
    assert_ext_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ext && cnt_q == CNT_W'(1) && wait_in) |=> run);

endmodule

// File: rtl/extbus_cs_ctrl.sv
module extbus_cs_ctrl
    import extbus_pkg::*;
#(
    parameter int AD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             req,
    input  logic             req_wr,
    input  logic             req_word,
    input  logic [AD_W-1:0]  req_addr,
    input  logic [AD_W-1:0]  req_wdata,
    output logic             ready,
    output logic             err,
    output logic             busy,
    output logic [AD_W-1:0]  rdata,
    output logic             ale,
    output logic             cs_n,
    output logic             cs_drive,
    output logic             rd_n,
    output logic             wr_n,
    output logic [AD_W-1:0]  ad_out,
    output logic             ad_oe,
    input  logic [AD_W-1:0]  ad_in,
    input  logic             wait_in
);

    localparam int LANE_W = AD_W / 2;
    localparam int CNT_W  = WCODE_W - 1;

    typedef struct packed {
        seq_st_e            st;
        logic               wr;
        logic               two;
        logic               second;
        logic               narrow;
        logic               ext;
        logic [CNT_W-1:0]   wlim;
        logic [RCODE_W-1:0] rcv_n;
        logic [RCODE_W-1:0] rcv_left;
        logic [AD_W-1:0]    addr;
        logic [AD_W-1:0]    wdata;
        logic [LANE_W-1:0]  lo;
        logic               err;
    } seq_t;

    seq_t s_d, s_q;
    cfg_t cfg;
    logic cfg_ok;
    logic strobing;
    logic strb_last;

    extbus_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .legal (cfg_ok)
    );

    assign strobing = (s_q.st == ST_STRB);

    extbus_wait_ctr #(.CNT_W(CNT_W)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (strobing),
        .lim     (s_q.wlim),
        .ext     (s_q.ext),
        .wait_in (wait_in),
        .last    (strb_last)
    );

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req) begin
                    if (cfg_ok) begin
                        s_d.st     = ST_ADDR;
                        s_d.wr     = req_wr;
                        s_d.two    = cfg.narrow && req_word;
                        s_d.second = 1'b0;
                        s_d.narrow = cfg.narrow;
                        s_d.ext    = &cfg.wcode;
                        s_d.wlim   = cfg.wcode[CNT_W-1:0];
                        s_d.rcv_n  = rcv_cycles(cfg.rcode);
                        s_d.addr   = req_addr;
                        s_d.wdata  = req_wdata;
                    end else begin
                        s_d.err = 1'b1;
                    end
                end
            end
            ST_ADDR: s_d.st = ST_STRB;
            ST_STRB: begin
                if (strb_last) begin
                    if (s_q.two && !s_q.second) begin
                        s_d.st     = ST_ADDR;
                        s_d.second = 1'b1;
                        s_d.lo     = ad_in[LANE_W-1:0];
                    end else if (!s_q.wr && s_q.rcv_n != '0) begin
                        s_d.st       = ST_RCV;
                        s_d.rcv_left = s_q.rcv_n - 1'b1;
                    end else begin
                        s_d.st = ST_IDLE;
                    end
                end
            end
            default: begin
                if (s_q.rcv_left == '0) s_d.st = ST_IDLE;
                else                    s_d.rcv_left = s_q.rcv_left - 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        ad_out = '0;
        if (s_q.st == ST_ADDR) begin
            ad_out = s_q.second ? s_q.addr + 1'b1 : s_q.addr;
        end else if (strobing && s_q.wr) begin
            if (!s_q.narrow)     ad_out = s_q.wdata;
            else if (s_q.second) ad_out = {{LANE_W{1'b0}}, s_q.wdata[AD_W-1:LANE_W]};
            else                 ad_out = {{LANE_W{1'b0}}, s_q.wdata[LANE_W-1:0]};
        end
        if (!s_q.narrow)  rdata = ad_in;
        else if (s_q.two) rdata = {ad_in[LANE_W-1:0], s_q.lo};
        else              rdata = {{LANE_W{1'b0}}, ad_in[LANE_W-1:0]};
    end

    assign ale      = (s_q.st == ST_ADDR);
    assign ad_oe    = ale || (strobing && s_q.wr);
    assign rd_n     = !(strobing && !s_q.wr);
    assign wr_n     = !(strobing && s_q.wr);
    assign cs_drive = cfg.pin_ctl && cfg.pin_fn;
    assign cs_n     = !((ale || strobing) && cs_drive);
    assign busy     = (s_q.st != ST_IDLE);
    assign ready    = strb_last && (!s_q.two || s_q.second);
    assign err      = s_q.err;

    assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!ale && (!rd_n || !wr_n)));

    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_cs_cover_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_drive && (ale || !rd_n || !wr_n)) |-> !cs_n);

    assert_cs_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !ale));

    assert_no_rcv_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !wr_n) |=> !busy);

    assert_rcv_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_RCV) |=> !ale);

    assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    assert_cs_undriven_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_drive |-> cs_n);

endmodule

// File: tb/extbus_cs_ctrl_test.sv
module extbus_cs_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [10:0] cfg_wdata = '0;
    logic        req = 1'b0, req_wr = 1'b0, req_word = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        ready, err, busy, ale, cs_n, cs_drive, rd_n, wr_n, ad_oe;
    logic [15:0] rdata, ad_out, ad_in;
    logic        wait_in = 1'b0;

    logic        narrow_b = 1'b0;
    logic [15:0] cur_addr = '0;
    int          n_tests = 0, n_fail = 0, cyc = 0;

    always #4 clk = ~clk;

    extbus_cs_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req(req), .req_wr(req_wr), .req_word(req_word), .req_addr(req_addr),
        .req_wdata(req_wdata), .ready(ready), .err(err), .busy(busy), .rdata(rdata),
        .ale(ale), .cs_n(cs_n), .cs_drive(cs_drive), .rd_n(rd_n), .wr_n(wr_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .wait_in(wait_in)
    );

    function automatic logic [15:0] model(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3C5A;
    endfunction

    logic [15:0] mdat;
    always_comb begin
        mdat  = model(cur_addr);
        ad_in = narrow_b ? {8'hEE, mdat[7:0]} : mdat;
    end

    task automatic check(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [10:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // bits: [50] wr [49] word [48] narrow [47:44] wait [43:42] rcv [41:39] ext
    //       [38:23] addr [22:7] wdata [6:2] expected strobe cycles [1:0] expected recovery
    localparam int NV = 11;
    localparam logic [50:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 3'd0, 16'h1234, 16'h0000, 5'd1, 2'd2},
        {1'b0, 1'b0, 1'b0, 4'd3,  2'd1, 3'd0, 16'h8001, 16'h0000, 5'd4, 2'd1},
        {1'b1, 1'b0, 1'b0, 4'd7,  2'd0, 3'd0, 16'h0F0F, 16'hBEEF, 5'd8, 2'd0},
        {1'b0, 1'b0, 1'b0, 4'd15, 2'd2, 3'd0, 16'h4444, 16'h0000, 5'd2, 2'd0},
        {1'b0, 1'b0, 1'b0, 4'd15, 2'd0, 3'd3, 16'h7A10, 16'h0000, 5'd5, 2'd2},
        {1'b1, 1'b0, 1'b0, 4'd15, 2'd1, 3'd2, 16'h0100, 16'hC0DE, 5'd4, 2'd0},
        {1'b0, 1'b1, 1'b1, 4'd2,  2'd1, 3'd0, 16'h20FF, 16'h0000, 5'd6, 2'd1},
        {1'b1, 1'b1, 1'b1, 4'd1,  2'd0, 3'd0, 16'h3000, 16'hA55A, 5'd4, 2'd0},
        {1'b0, 1'b0, 1'b1, 4'd0,  2'd2, 3'd0, 16'h0042, 16'h0000, 5'd1, 2'd0},
        {1'b0, 1'b1, 1'b1, 4'd15, 2'd0, 3'd1, 16'hFFFE, 16'h0000, 5'd6, 2'd2},
        {1'b1, 1'b0, 1'b1, 4'd5,  2'd2, 3'd0, 16'h5555, 16'h12C3, 5'd6, 2'd0}
    };

    task automatic do_access(input logic [50:0] v, input logic set_cfg, input logic pins);
        logic        wr, word, nar;
        logic [3:0]  wc;
        logic [1:0]  rc, exp_rcv;
        logic [2:0]  ext;
        logic [15:0] addr, wd, got, exp_d, m0, m1;
        logic [15:0] wb [2];
        int n_ale, n_str, n_rdy, n_rcv, cs_bad, a_bad, s_bad, k, exp_ale;
        {wr, word, nar, wc, rc, ext, addr, wd} = v[50:7];
        exp_rcv = v[1:0];
        n_ale = 0; n_str = 0; n_rdy = 0; n_rcv = 0; cs_bad = 0; a_bad = 0; s_bad = 0; k = 0;
        got = '0; wb[0] = '0; wb[1] = '0;
        if (set_cfg) write_cfg({pins, pins, 2'b00, nar, rc, wc});
        narrow_b = nar;
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_word = word; req_addr = addr; req_wdata = wd;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            req = 1'b0;
            wait_in = 1'b0;
            if (!busy) break;
            if (ale) begin
                if (ad_out !== addr + 16'(n_ale) || !ad_oe) a_bad++;
                cur_addr = ad_out;
                if (cs_n !== !pins) cs_bad++;
                n_ale++; k = 0;
            end else if (!rd_n || !wr_n) begin
                if (wr ? !rd_n : !wr_n) s_bad++;
                n_str++;
                wait_in = (k >= 1 && k <= int'(ext));
                #1;
                if (cs_n !== !pins) cs_bad++;
                if (!wr_n && ad_oe && n_ale > 0) wb[n_ale-1] = ad_out;
                if (ready) begin n_rdy++; got = rdata; end
                k++;
            end else begin
                if (n_rdy > 0) n_rcv++;
                if (!cs_n) cs_bad++;
            end
        end
        wait_in = 1'b0;
        exp_ale = (nar && word) ? 2 : 1;
        check(n_ale == exp_ale, "R2/R9 address cycles", n_ale, exp_ale);
        check(a_bad == 0 && s_bad == 0, "R2 address and strobe select", a_bad + s_bad, 0);
        check(cs_bad == 0, pins ? "R2 chip select window" : "R11 undriven chip select", cs_bad, 0);
        check(n_str == int'(v[6:2]), wc == 4'd15 ? "R4 extended strobe length" : "R3 fixed strobe length",
              n_str, v[6:2]);
        check(n_rdy == 1, "R10 ready pulse count", n_rdy, 1);
        check(n_rcv == int'(exp_rcv), "R6 recovery cycles", n_rcv, exp_rcv);
        m0 = model(addr); m1 = model(addr + 16'd1);
        if (!wr) begin
            if (!nar)     exp_d = m0;
            else if (word) exp_d = {m1[7:0], m0[7:0]};
            else          exp_d = {8'h00, m0[7:0]};
            check(got == exp_d, nar ? "R9 narrow read data" : "R8 wide read data", got, exp_d);
        end else begin
            if (!nar)      check(wb[0] == wd, "R8 wide write data", wb[0], wd);
            else if (word) check({wb[1][7:0], wb[0][7:0]} == wd && wb[0][15:8] == 8'h00,
                                 "R9 narrow word write", {wb[1][7:0], wb[0][7:0]}, wd);
            else           check(wb[0] == {8'h00, wd[7:0]}, "R9 narrow byte write", wb[0], {8'h00, wd[7:0]});
        end
    endtask

    task automatic err_case(input logic [10:0] v, input string what);
        write_cfg(v);
        @(negedge clk);
        req = 1'b1; req_wr = 1'b0; req_word = 1'b0;
        @(negedge clk);
        req = 1'b0;
        check(err && !busy && !ale, what, {err, busy, ale}, 3'b100);
        @(negedge clk);
        check(!err && !busy && !ale, "R5 error is a single pulse", {err, busy, ale}, 3'b000);
    endtask

    task automatic held_req(input logic [1:0] rc, input int exp_gap, input string what);
        int t_r, gap;
        logic done;
        t_r = -1; gap = -1; done = 1'b0;
        write_cfg({1'b1, 1'b1, 2'b00, 1'b0, rc, 4'd0});
        narrow_b = 1'b0;
        @(negedge clk);
        req = 1'b1; req_wr = 1'b0; req_word = 1'b0; req_addr = 16'h0A0A;
        for (int c = 0; c < 40 && !done; c++) begin
            @(negedge clk);
            if (ready && t_r < 0) t_r = c;
            else if (ale && t_r >= 0) begin gap = c - t_r; req = 1'b0; done = 1'b1; end
        end
        req = 1'b0;
        check(gap == exp_gap, what, gap, exp_gap);
        for (int c = 0; c < 40 && busy; c++) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cs_n && rd_n && wr_n && !ale && !busy && !ready && !err && !cs_drive,
              "R1 reset outputs", {cs_n, rd_n, wr_n, ale, busy, ready, err, cs_drive}, 8'hE0);
        // R1 default configuration: 16-bit read, 1-cycle strobe, 2 recovery, pin undriven
        do_access({1'b0, 1'b0, 1'b0, 4'd0, 2'd0, 3'd0, 16'h00C4, 16'h0000, 5'd1, 2'd2}, 1'b0, 1'b0);

        // vector table: R2 R3 R4 R6 R8 R9 R10
        for (int i = 0; i < NV; i++) do_access(VEC[i], 1'b1, 1'b1);

        // R5 illegal configurations
        err_case({1'b1, 1'b1, 2'b00, 1'b0, 2'b00, 4'b1010}, "R5 reserved wait code");
        err_case({1'b1, 1'b1, 2'b00, 1'b0, 2'b11, 4'b0001}, "R5 reserved recovery code");
        err_case({1'b1, 1'b1, 2'b01, 1'b0, 2'b00, 4'b0000}, "R5 bad waveform code");

        // R7 request held through recovery
        held_req(2'b00, 4, "R7 gap after 2 recovery cycles");
        held_req(2'b10, 2, "R7 gap with no recovery");

        // R11 pin enables
        write_cfg({1'b0, 1'b1, 2'b00, 1'b0, 2'b00, 4'd0});
        @(negedge clk);
        check(!cs_drive && cs_n, "R11 control enable alone", cs_drive, 0);
        write_cfg({1'b1, 1'b0, 2'b00, 1'b0, 2'b00, 4'd0});
        @(negedge clk);
        check(!cs_drive && cs_n, "R11 function enable alone", cs_drive, 0);
        write_cfg({1'b1, 1'b1, 2'b00, 1'b0, 2'b00, 4'd0});
        @(negedge clk);
        check(cs_drive, "R11 both enables", cs_drive, 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule